// File: doc/BRIEF.md
# Character-Coded Address Validity Checker

This block sits between an address source and a character-addressed store. It takes a storage address held as three 8-bit characters: hundreds, tens and units. Each character carries a decimal digit code. The zone bits over the hundreds and units characters carry the thousands block, so any position from 0 to 15999 can be reached with only three characters. The block turns the address into a binary position number as soon as the inputs settle.

On each check strobe, the block looks for four kinds of fault:
- a character whose parity is wrong;
- a digit code that is not legal;
- an address at or above the installed capacity;
- a single-position step that would run off either end of storage.

Each fault has its own flag. The flags are sticky until reset, and any of them raises the stop output.

Top module: `addr_validity_chk`

## Requirements
- R1: Each character is laid out as bit 7 check, bit 6 word mark, bit 5 zone B, bit 4 zone A, and bits 3..0 digit 8-4-2-1. The digit code 1010 means 0, and codes 0001..1001 mean 1..9. The output pos_o is 1000*T + 100*H + 10*T' + U, where H, T' and U are the hundreds, tens and units digit values. T is the thousands block: hundreds zone A = 1, hundreds zone B = 2, units zone A = 4, units zone B = 8, summed. The tens zone bits are ignored.
- R2: If any of the three characters has an even number of set bits across all 8 bits (word mark included), err_o[0] is raised.
- R3: If any character's digit code is not one of the ten legal codes, err_o[1] is raised, even when its parity is correct.
- R4: cap_sel selects the capacity: 0 is 1400, 1 is 2000, 2 is 4000, 3 is 8000, 4 is 12000, and 5 to 7 are 16000. A decoded position at or above the selected capacity raises err_o[2].
- R5: A step request with step_up low at position 0 raises err_o[3], unless mode_clear is high.
- R6: A step request with step_up high at position capacity-1 raises err_o[4], unless mode_scan is high.
- R7: stop_o is high exactly when any bit of err_o is high.
- R8: Flags are set only on a rising edge where chk_stb is high. They never clear except through the synchronous active-high reset, which clears all of them.
- R9: When any digit code is illegal, the checks of R4, R5 and R6 raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chr_hun | input | 8 | Hundreds character |
| chr_ten | input | 8 | Tens character |
| chr_uni | input | 8 | Units character |
| cap_sel | input | 3 | Installed capacity select |
| chk_stb | input | 1 | Check strobe; flags update on this cycle |
| step_req | input | 1 | Address is being stepped by one position |
| step_up | input | 1 | Step direction: 1 is +1, 0 is -1 |
| mode_clear | input | 1 | Clear operation in progress (exempts low wrap) |
| mode_scan | input | 1 | Scan or print-out in progress (exempts high wrap) |
| pos_o | output | 14 | Decoded binary position |
| err_o | output | 5 | Sticky flags: 0 parity, 1 digit, 2 range, 3 low wrap, 4 high wrap |
| stop_o | output | 1 | System stop |

## Verification
pos_o is purely combinational, so the bench reads it one time step after driving the characters, with no clock edge in between. The flags sit one register away from the strobe. The bench therefore raises chk_stb at a falling edge, lets one rising edge pass, drops the strobe at the next falling edge and samples err_o and stop_o there. Stickiness is checked by clocking several further edges with faulty inputs and no strobe, then reading the flags again.

// File: rtl/addr_validity_chk.sv
module addr_validity_chk #(
  parameter int CHAR_W = 8,
  parameter int POS_W  = 14,
  parameter int N_ERR  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] chr_hun,
  input  logic [CHAR_W-1:0] chr_ten,
  input  logic [CHAR_W-1:0] chr_uni,
  input  logic [2:0]        cap_sel,
  input  logic              chk_stb,
  input  logic              step_req,
  input  logic              step_up,
  input  logic              mode_clear,
  input  logic              mode_scan,
  output logic [POS_W-1:0]  pos_o,
  output logic [N_ERR-1:0]  err_o,
  output logic              stop_o
);
  localparam int NCH = 3;
  localparam int E_PAR = 0, E_DIG = 1, E_RNG = 2, E_LO = 3, E_HI = 4;

  logic [CHAR_W-1:0] chr [NCH];
  logic [NCH-1:0]    par_ok, dig_ok;
  logic [3:0]        dval [NCH];
  logic [3:0]        thou;
  logic [POS_W-1:0]  cap_lim;
  logic              all_dig;
  logic [N_ERR-1:0]  hit;

  assign chr[0] = chr_uni;
  assign chr[1] = chr_ten;
  assign chr[2] = chr_hun;

  for (genvar i = 0; i < NCH; i++) begin : g_chr
    logic [3:0] code;
    assign code      = chr[i][3:0];
    assign par_ok[i] = ^chr[i];
    assign dig_ok[i] = (code == 4'b1010) || (code >= 4'd1 && code <= 4'd9);
    assign dval[i]   = (code == 4'b1010) ? 4'd0 : code;
  end

  assign thou = {chr[0][5], chr[0][4], chr[2][5], chr[2][4]};

  assign pos_o = POS_W'(thou) * POS_W'(1000) + POS_W'(dval[2]) * POS_W'(100)
               + POS_W'(dval[1]) * POS_W'(10) + POS_W'(dval[0]);

  always_comb begin
    case (cap_sel)
      3'd0:    cap_lim = POS_W'(1400);
      3'd1:    cap_lim = POS_W'(2000);
      3'd2:    cap_lim = POS_W'(4000);
      3'd3:    cap_lim = POS_W'(8000);
      3'd4:    cap_lim = POS_W'(12000);
      default: cap_lim = POS_W'(16000);
    endcase
  end

  assign all_dig    = &dig_ok;
  assign hit[E_PAR] = ~&par_ok;
  assign hit[E_DIG] = ~all_dig;
  assign hit[E_RNG] = all_dig && (pos_o >= cap_lim);
  assign hit[E_LO]  = all_dig && step_req && !step_up && (pos_o == '0) && !mode_clear;
  assign hit[E_HI]  = all_dig && step_req && step_up && (pos_o == cap_lim - POS_W'(1)) && !mode_scan;

  always_ff @(posedge clk) begin
    if (rst)          err_o <= '0;
    else if (chk_stb) err_o <= err_o | hit;
  end

  assign stop_o = |err_o;

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(err_o) & ~err_o) == '0);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !chk_stb |=> $stable(err_o));
  a_r3_bad_digit: assert property (@(posedge clk) disable iff (rst)
    (chk_stb && !all_dig) |=> err_o[E_DIG]);
  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    (chk_stb && all_dig && pos_o >= cap_lim) |=> err_o[E_RNG]);
  a_r5_clear_exempt: assert property (@(posedge clk) disable iff (rst)
    (chk_stb && mode_clear) |=> (err_o[E_LO] == $past(err_o[E_LO])));
  a_r6_scan_exempt: assert property (@(posedge clk) disable iff (rst)
    (chk_stb && mode_scan) |=> (err_o[E_HI] == $past(err_o[E_HI])));
  a_r7_stop: assert property (@(posedge clk) disable iff (rst)
    (err_o != '0) |-> stop_o);
endmodule

// File: tb/addr_validity_chk_tb.sv
module addr_validity_chk_tb_top;
  logic clk = 0, rst = 1;
  logic [7:0] c_h = 0, c_t = 0, c_u = 0;
  logic [2:0] cap = 3'd5;
  logic stb = 0, sreq = 0, sup = 0, mclr = 0, mscan = 0;
  logic [13:0] pos;
  logic [4:0] err;
  logic stop;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_validity_chk dut_i (
    .clk(clk), .rst(rst), .chr_hun(c_h), .chr_ten(c_t), .chr_uni(c_u),
    .cap_sel(cap), .chk_stb(stb), .step_req(sreq), .step_up(sup),
    .mode_clear(mclr), .mode_scan(mscan), .pos_o(pos), .err_o(err), .stop_o(stop));

  function automatic logic [7:0] enc(int d, bit zb, bit za, bit wm);
    logic [5:0] data;
    data = {zb, za, (d == 0) ? 4'b1010 : 4'(d)};
    return {~(^{wm, data}), wm, data};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_addr(int a);
    int th = a / 1000;
    c_h = enc((a / 100) % 10, th[1], th[0], 0);
    c_t = enc((a / 10) % 10, 0, 0, 0);
    c_u = enc(a % 10, th[3], th[2], 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; stb = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic strobe(bit req, bit up, bit clr, bit scan);
    @(negedge clk);
    sreq = req; sup = up; mclr = clr; mscan = scan; stb = 1;
    @(negedge clk);
    stb = 0; sreq = 0; mclr = 0; mscan = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(err == 0, "R8 reset", err, 0);
    chk(stop == 0, "R7 reset", stop, 0);
  endtask

  task automatic t_decode();
    int al[6] = '{0, 3099, 11959, 15999, 4321, 8000};
    do_reset(); cap = 3'd5;
    foreach (al[i]) begin
      set_addr(al[i]); #1;
      chk(pos == 14'(al[i]), "R1 decode", pos, al[i]);
      strobe(0, 0, 0, 0);
      chk(err == 0, "R9 clean address", err, 0);
    end
    c_t = enc(5, 1, 1, 1); #1;
    chk(pos == 14'(8050), "R1 tens zones ignored", pos, 8050);
  endtask

  task automatic t_parity();
    do_reset(); cap = 3'd5;
    set_addr(1234); c_u = enc(4, 0, 0, 1);
    strobe(0, 0, 0, 0);
    chk(err == 0, "R2 word mark counted", err, 0);
    c_t = c_t ^ 8'h80;
    strobe(0, 0, 0, 0);
    chk(err == 5'b00001, "R2 parity flag", err, 1);
    chk(stop == 1, "R7 stop on parity", stop, 1);
  endtask

  task automatic t_badchar();
    do_reset(); cap = 3'd0;
    set_addr(15999); c_u = 8'b1000_0000;
    strobe(1, 0, 0, 0);
    chk(err == 5'b00010, "R3 illegal digit only", err, 2);
    chk(err == 5'b00010, "R9 range suppressed", err, 2);
    do_reset();
    set_addr(1000); c_u = 8'b1000_1100;
    strobe(1, 0, 0, 0);
    chk(err == 5'b00010, "R3 code 1100", err, 2);
  endtask

  task automatic t_range();
    int lim[3] = '{1400, 2000, 12000};
    int sel[3] = '{0, 1, 4};
    foreach (lim[i]) begin
      do_reset(); cap = 3'(sel[i]);
      set_addr(lim[i] - 1); strobe(0, 0, 0, 0);
      chk(err == 0, "R4 below capacity", err, 0);
      set_addr(lim[i]); strobe(0, 0, 0, 0);
      chk(err == 5'b00100, "R4 at capacity", err, 4);
    end
  endtask

  task automatic t_wrap_lo();
    do_reset(); cap = 3'd5; set_addr(0);
    strobe(1, 0, 1, 0);
    chk(err == 0, "R5 clear exempt", err, 0);
    strobe(1, 1, 0, 0);
    chk(err == 0, "R5 up from 0", err, 0);
    set_addr(1); strobe(1, 0, 0, 0);
    chk(err == 0, "R5 down from 1", err, 0);
    set_addr(0); strobe(1, 0, 0, 0);
    chk(err == 5'b01000, "R5 low wrap", err, 8);
  endtask

  task automatic t_wrap_hi();
    do_reset(); cap = 3'd2; set_addr(3999);
    strobe(1, 1, 0, 1);
    chk(err == 0, "R6 scan exempt", err, 0);
    strobe(1, 1, 0, 0);
    chk(err == 5'b10000, "R6 high wrap 4000", err, 16);
    do_reset(); cap = 3'd5; set_addr(15999);
    strobe(1, 1, 0, 0);
    chk(err == 5'b10000, "R6 high wrap 16000", err, 16);
  endtask

  task automatic t_sticky();
    do_reset(); cap = 3'd0; set_addr(1500);
    strobe(0, 0, 0, 0);
    chk(err == 5'b00100, "R8 set", err, 4);
    set_addr(100); strobe(0, 0, 0, 0);
    chk(err == 5'b00100, "R8 sticky", err, 4);
    c_u = 8'h00; sreq = 1;
    repeat (4) @(negedge clk);
    sreq = 0;
    chk(err == 5'b00100, "R8 no strobe no change", err, 4);
    do_reset();
    chk(err == 0 && stop == 0, "R8 reset clears", err, 0);
  endtask

  initial begin
    t_reset(); t_decode(); t_parity(); t_badchar();
    t_range(); t_wrap_lo(); t_wrap_hi(); t_sticky();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule